// File: doc/BRIEF.md
# Byte-wide keyboard controller register block

This block is the register face of a legacy-style PC keyboard controller. A host reaches it through a simple single-cycle request interface. Each request carries a byte address offset and a byte count. The block decodes two ports. The data port carries output bytes towards the host and device bytes or command parameters from the host. The command/status port returns status on a read and accepts controller commands on a write.

Inside the block are a 16-entry output byte queue, a control byte, an output-port byte and a small command-parameter tracker. The tracker decides whether a data-port write is a parameter for a pending command or a byte meant for the keyboard. A separate push port lets neighbouring logic, such as a key-event source, insert bytes into the queue. The block raises a one-clock keyboard interrupt pulse and a one-clock system reset pulse. It also keeps saturating event counters.

Top module: `kbc_regif`

## Requirements
- R1: After reset the status byte reads 0x10, the control byte reads 0x05, the output-port byte reads 0x00, the queue is empty and all five counters are 0.
- R2: The data port is at offset 0 and the command/status port is at offset 4. A read returns `rd_valid` high with its `rd_data` in the cycle after the request. A request whose `req_size` is not 1 changes no state and counts as a missed read or missed write. A request at any other offset does the same, and a missed read returns 0.
- R3: Status bit 0 means output data is available. Bit 3 means a command parameter is expected. Bit 4 means the keyboard is enabled, and it is always 1. All other status bits are 0.
- R4: Command 0x20 empties the queue and then queues the control byte. Command 0xD0 empties the queue and then queues the output-port byte.
- R5: Command 0x60 empties the queue, sets status bit 3 and remembers the command. Command 0xD1 sets status bit 3 and remembers the command, and it leaves the queue untouched.
- R6: A data-port write while status bit 3 is set stores the byte into the control byte (pending 0x60) or the output-port byte (pending 0xD1). It clears bit 3 and raises no interrupt.
- R7: A data-port write while status bit 3 is clear empties the queue, queues 0xFA and requests a keyboard interrupt.
- R8: Command 0xFE pulses `sys_reset` for one cycle and changes nothing else. Every other command value outside 0x20, 0x60, 0xD0, 0xD1 and 0xFE changes no state and counts as a missed write.
- R9: A data-port read pops the oldest queued byte, or returns 0 when the queue is empty. If bytes remain after the pop, a keyboard interrupt is requested.
- R10: The queue holds 16 bytes in first-in first-out order. A push into a full queue is dropped and pulses `push_rejected` in the following cycle. Status bit 0 is set by any push attempt and cleared when a pop empties the queue or a flush occurs.
- R11: A keyboard interrupt request produces a one-cycle `kbd_irq` pulse in the following cycle only while control bit 0 is set. Otherwise it is suppressed.
- R12: `push_ready` is low in any cycle with `req_valid` high, and a push offered in such a cycle is dropped. An accepted push into a non-full queue requests a keyboard interrupt.
- R13: The counters `cnt_read`, `cnt_write`, `cnt_miss_rd`, `cnt_miss_wr` and `cnt_reset` count good reads, good writes, missed reads, missed writes and reset commands. Each holds at 0xFFFF once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Byte offset of the access |
| req_size | input | 3 | Number of bytes in the access |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid (cycle after request) |
| rd_data | output | 8 | Read response byte |
| push_valid | input | 1 | Insert a byte into the queue |
| push_data | input | 8 | Byte to insert |
| push_ready | output | 1 | Push port accepts this cycle |
| push_rejected | output | 1 | Pulse: last accepted push met a full queue |
| kbd_irq | output | 1 | Keyboard interrupt pulse |
| sys_reset | output | 1 | System reset pulse |
| cnt_read | output | 16 | Good read count |
| cnt_write | output | 16 | Good write count |
| cnt_miss_rd | output | 16 | Missed read count |
| cnt_miss_wr | output | 16 | Missed write count |
| cnt_reset | output | 16 | Reset command count |

## Verification
The hardest state to reach from the ports is a counter pinned at 0xFFFF. The bench gets there by holding a back-to-back status read for more than 65535 cycles and then checks that further reads leave it there. A second hard case is the queue pointer wrap with data still inside. It is reached by partly filling the queue, draining part of it, and then refilling it to full through the push port, with a bench-side byte list giving the expected order. The rule that a 0xD1 command does not flush, unlike 0x60, is seen only by queueing a byte first and then reading it back after the parameter write.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] OP_RD_CTRL   = 8'h20;
  localparam logic [7:0] OP_WR_CTRL   = 8'h60;
  localparam logic [7:0] OP_RD_OUTP   = 8'hD0;
  localparam logic [7:0] OP_WR_OUTP   = 8'hD1;
  localparam logic [7:0] OP_PULSE_RST = 8'hFE;
  localparam logic [7:0] ACK_BYTE     = 8'hFA;
  localparam logic [7:0] CTRL_INIT    = 8'h05;
  localparam int unsigned CTRL_IRQ_EN = 0;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_MISS_RD,
    ACT_RD_STAT,
    ACT_RD_DATA,
    ACT_MISS_WR,
    ACT_RST,
    ACT_RD_CTRL,
    ACT_RD_OUTP,
    ACT_CMD_CTRL,
    ACT_CMD_OUTP,
    ACT_PARAM,
    ACT_DEV_WR
  } kbc_act_e;

  function automatic logic [7:0] pack_status(input logic avail, input logic param);
    logic [7:0] s;
    s    = 8'h10;
    s[0] = avail;
    s[3] = param;
    return s;
  endfunction

  function automatic logic act_is_flush(input kbc_act_e a);
    return (a == ACT_RD_CTRL) || (a == ACT_RD_OUTP) || (a == ACT_CMD_CTRL) || (a == ACT_DEV_WR);
  endfunction

  function automatic logic act_is_good_wr(input kbc_act_e a);
    return (a == ACT_RST) || (a == ACT_RD_CTRL) || (a == ACT_RD_OUTP) || (a == ACT_CMD_CTRL) ||
           (a == ACT_CMD_OUTP) || (a == ACT_PARAM) || (a == ACT_DEV_WR);
  endfunction
endpackage

// File: rtl/kbc_req_decode.sv
module kbc_req_decode import kbc_pkg::*; #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned CMD_OFS  = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [7:0]        req_wdata,
  input  logic              param_pending,
  output kbc_act_e          act
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
  localparam logic [SIZE_W-1:0] ONE_B  = SIZE_W'(1);

  always_comb begin
    act = ACT_NONE;
    if (req_valid) begin
      if (!req_write) begin
        if (req_size != ONE_B)      act = ACT_MISS_RD;
        else if (req_addr == A_DATA) act = ACT_RD_DATA;
        else if (req_addr == A_CMD)  act = ACT_RD_STAT;
        else                         act = ACT_MISS_RD;
      end else begin
        if (req_size != ONE_B) begin
          act = ACT_MISS_WR;
        end else if (req_addr == A_CMD) begin
          case (req_wdata)
            OP_RD_CTRL:   act = ACT_RD_CTRL;
            OP_WR_CTRL:   act = ACT_CMD_CTRL;
            OP_RD_OUTP:   act = ACT_RD_OUTP;
            OP_WR_OUTP:   act = ACT_CMD_OUTP;
            OP_PULSE_RST: act = ACT_RST;
            default:      act = ACT_MISS_WR;
          endcase
        end else if (req_addr == A_DATA) begin
          act = param_pending ? ACT_PARAM : ACT_DEV_WR;
        end else begin
          act = ACT_MISS_WR;
        end
      end
    end
  end
endmodule

// File: rtl/kbc_byte_queue.sv
module kbc_byte_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full,
  output logic                         overflow
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_take, rd_take;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNT_FULL);
  assign overflow = wr_en && full && !flush;
  assign wr_take  = wr_en && (flush || !full);
  assign rd_take  = rd_en && !empty && !flush;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_take) mem[flush ? '0 : wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= wr_take ? PTR_W'(1 % DEPTH) : '0;
      count  <= wr_take ? CNT_W'(1) : '0;
    end else begin
      if (wr_take) wr_ptr <= ptr_step(wr_ptr);
      if (rd_take) rd_ptr <= ptr_step(rd_ptr);
      count <= count + CNT_W'(wr_take) - CNT_W'(rd_take);
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush && !rd_en) |=> (count == CNT_FULL));
endmodule

// File: rtl/kbc_sat_counter.sv
module kbc_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v, input logic up);
    return (up && (v != TOP)) ? v + W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= sat_step(value, inc);
  end

  p_hold_top_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (value == TOP) |=> (value == TOP));
endmodule

// File: rtl/kbc_regif.sv
module kbc_regif import kbc_pkg::*; #(
  parameter int unsigned QDEPTH   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned DATA_OFS = 0,
  parameter int unsigned CMD_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  output logic              push_ready,
  output logic              push_rejected,
  output logic              kbd_irq,
  output logic              sys_reset,
  output logic [CNT_W-1:0]  cnt_read,
  output logic [CNT_W-1:0]  cnt_write,
  output logic [CNT_W-1:0]  cnt_miss_rd,
  output logic [CNT_W-1:0]  cnt_miss_wr,
  output logic [CNT_W-1:0]  cnt_reset
);
  localparam int unsigned QCNT_W = $clog2(QDEPTH + 1);
  localparam int unsigned NCNT   = 5;
  localparam int unsigned IX_RD = 0, IX_WR = 1, IX_MRD = 2, IX_MWR = 3, IX_RST = 4;

  kbc_act_e          act;
  logic [7:0]        ctrl_q, outp_q, pend_cmd_q;
  logic              param_q, avail_q;
  logic              push_fire, irq_req;
  logic              q_flush, q_wr, q_rd, q_empty, q_full, q_ovf;
  logic [7:0]        q_wdata, q_head;
  logic [QCNT_W-1:0] q_count;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  kbc_req_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)
  ) u_dec (
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .param_pending(param_q),
    .act          (act)
  );

  // Bus traffic owns the queue; the push port waits for an idle bus cycle.
  assign push_ready = !req_valid;
  assign push_fire  = push_valid && push_ready;

  assign q_flush = act_is_flush(act);
  assign q_wr    = (act == ACT_RD_CTRL) || (act == ACT_RD_OUTP) || (act == ACT_DEV_WR) || push_fire;
  assign q_rd    = (act == ACT_RD_DATA) && !q_empty;

  always_comb begin
    case (act)
      ACT_RD_CTRL: q_wdata = ctrl_q;
      ACT_RD_OUTP: q_wdata = outp_q;
      ACT_DEV_WR:  q_wdata = ACK_BYTE;
      default:     q_wdata = push_data;
    endcase
  end

  kbc_byte_queue #(.DEPTH(QDEPTH), .W(8)) u_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (q_flush),
    .wr_en   (q_wr),
    .wr_data (q_wdata),
    .rd_en   (q_rd),
    .head    (q_head),
    .count   (q_count),
    .empty   (q_empty),
    .full    (q_full),
    .overflow(q_ovf)
  );

  assign irq_req = (act == ACT_DEV_WR) ||
                   ((act == ACT_RD_DATA) && (q_count > QCNT_W'(1))) ||
                   (push_fire && !q_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_INIT;
      outp_q     <= '0;
      pend_cmd_q <= '0;
      param_q    <= 1'b0;
    end else begin
      case (act)
        ACT_CMD_CTRL: begin param_q <= 1'b1; pend_cmd_q <= OP_WR_CTRL; end
        ACT_CMD_OUTP: begin param_q <= 1'b1; pend_cmd_q <= OP_WR_OUTP; end
        ACT_PARAM: begin
          param_q <= 1'b0;
          if (pend_cmd_q == OP_WR_CTRL)      ctrl_q <= req_wdata;
          else if (pend_cmd_q == OP_WR_OUTP) outp_q <= req_wdata;
        end
        default: ;
      endcase
    end
  end

  // Data-available flag follows the push-attempt / empty-on-pop / flush rules.
  always_ff @(posedge clk) begin
    if (!rst_n)                         avail_q <= 1'b0;
    else if (q_wr)                      avail_q <= 1'b1;
    else if (q_flush)                   avail_q <= 1'b0;
    else if (q_rd && q_count == QCNT_W'(1)) avail_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      kbd_irq       <= 1'b0;
      sys_reset     <= 1'b0;
      push_rejected <= 1'b0;
    end else begin
      rd_valid      <= req_valid && !req_write;
      kbd_irq       <= irq_req && ctrl_q[CTRL_IRQ_EN];
      sys_reset     <= (act == ACT_RST);
      push_rejected <= q_ovf;
      case (act)
        ACT_RD_STAT: rd_data <= pack_status(avail_q, param_q);
        ACT_RD_DATA: rd_data <= q_empty ? 8'h00 : q_head;
        default:     rd_data <= 8'h00;
      endcase
    end
  end

  assign cnt_inc[IX_RD]  = (act == ACT_RD_STAT) || (act == ACT_RD_DATA);
  assign cnt_inc[IX_WR]  = act_is_good_wr(act);
  assign cnt_inc[IX_MRD] = (act == ACT_MISS_RD);
  assign cnt_inc[IX_MWR] = (act == ACT_MISS_WR);
  assign cnt_inc[IX_RST] = (act == ACT_RST);

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    kbc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cnt_inc[i]),
      .value(cnt_val[i])
    );
  end

  assign cnt_read    = cnt_val[IX_RD];
  assign cnt_write   = cnt_val[IX_WR];
  assign cnt_miss_rd = cnt_val[IX_MRD];
  assign cnt_miss_wr = cnt_val[IX_MWR];
  assign cnt_reset   = cnt_val[IX_RST];

  p_avail_tracks_queue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    avail_q == !q_empty);

  p_param_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PARAM) |=> !param_q);

  p_reset_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_RST) |=> ($stable(ctrl_q) && $stable(outp_q) && $stable(q_count) && $stable(param_q)));

  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTRL_IRQ_EN] && !param_q && act == ACT_DEV_WR) |=> !kbd_irq);

  p_push_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && push_valid && q_empty && act == ACT_RD_STAT) |=> q_empty);
endmodule

// File: tb/kbc_regif_tb.sv
`timescale 1ns/1ps
module kbc_regif_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0, req_size = '0;
  logic [7:0] req_wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic push_ready, push_rejected, kbd_irq, sys_reset;
  logic [15:0] cnt_read, cnt_write, cnt_miss_rd, cnt_miss_wr, cnt_reset;

  always #4 clk = ~clk;

  kbc_regif u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .push_rejected(push_rejected), .kbd_irq(kbd_irq),
    .sys_reset(sys_reset), .cnt_read(cnt_read), .cnt_write(cnt_write),
    .cnt_miss_rd(cnt_miss_rd), .cnt_miss_wr(cnt_miss_wr), .cnt_reset(cnt_reset)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] s_rd;
  logic s_rv, s_irq, s_rst, s_rej;
  int exp_rd = 0, exp_wr = 0, exp_mrd = 0, exp_mwr = 0, exp_rst = 0;
  logic [7:0] model_q[$];

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic bit listed(input logic [7:0] v);
    return v == 8'h20 || v == 8'h60 || v == 8'hD0 || v == 8'hD1 || v == 8'hFE;
  endfunction

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_tests++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic acc(input logic wr, input logic [2:0] a, input logic [2:0] sz, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    s_rd = rd_data; s_rv = rd_valid; s_irq = kbd_irq; s_rst = sys_reset; s_rej = push_rejected;
    if (!wr) begin
      if (sz == 3'd1 && (a == 3'd0 || a == 3'd4)) exp_rd = sat(exp_rd + 1);
      else exp_mrd = sat(exp_mrd + 1);
    end else if (sz != 3'd1 || (a != 3'd0 && a != 3'd4)) begin
      exp_mwr = sat(exp_mwr + 1);
    end else if (a == 3'd0 || listed(d)) begin
      exp_wr = sat(exp_wr + 1);
      if (a == 3'd4 && d == 8'hFE) exp_rst = sat(exp_rst + 1);
    end else begin
      exp_mwr = sat(exp_mwr + 1);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
    s_irq = kbd_irq; s_rej = push_rejected;
  endtask

  function automatic logic [7:0] stat(input bit avail, input bit param);
    return 8'h10 | (avail ? 8'h01 : 8'h00) | (param ? 8'h08 : 8'h00);
  endfunction

  task automatic chk_counters(input string tag);
    chk({tag, " R13 cnt_read"}, cnt_read, exp_rd);
    chk({tag, " R13 cnt_write"}, cnt_write, exp_wr);
    chk({tag, " R13 cnt_miss_rd"}, cnt_miss_rd, exp_mrd);
    chk({tag, " R13 cnt_miss_wr"}, cnt_miss_wr, exp_mwr);
    chk({tag, " R13 cnt_reset"}, cnt_reset, exp_rst);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 counters zero", cnt_read | cnt_write | cnt_miss_rd | cnt_miss_wr | cnt_reset, 0);
    chk("R1 irq idle", kbd_irq, 0);
    chk("R12 push_ready idle", push_ready, 1);
    acc(0, 4, 1, 0); chk("R1 R3 status after reset", s_rd, 8'h10);
    chk("R2 rd_valid", s_rv, 1);
    acc(0, 0, 1, 0); chk("R9 empty read", s_rd, 0); chk("R9 no irq on empty", s_irq, 0);
    acc(1, 4, 1, 8'h20); acc(0, 0, 1, 0); chk("R1 R4 control reset", s_rd, 8'h05);
    acc(1, 4, 1, 8'hD0); acc(0, 0, 1, 0); chk("R1 R4 outport reset", s_rd, 8'h00);

    // R5 R6 parameter writes
    acc(1, 4, 1, 8'h60); acc(0, 4, 1, 0); chk("R5 R3 param bit", s_rd, stat(0, 1));
    acc(1, 0, 1, 8'h52); chk("R6 no irq on param", s_irq, 0);
    acc(0, 4, 1, 0); chk("R6 param cleared", s_rd, stat(0, 0));
    acc(1, 4, 1, 8'h20); acc(0, 0, 1, 0); chk("R6 control written", s_rd, 8'h52);
    acc(1, 4, 1, 8'h60); acc(1, 0, 1, 8'h05);
    acc(1, 4, 1, 8'hD1); acc(1, 0, 1, 8'h5A);
    acc(1, 4, 1, 8'hD0); acc(0, 0, 1, 0); chk("R6 outport written", s_rd, 8'h5A);
    push(8'h11); chk("R12 push irq", s_irq, 1);
    acc(1, 4, 1, 8'hD1); acc(0, 4, 1, 0); chk("R5 D1 keeps queue", s_rd, stat(1, 1));
    acc(1, 0, 1, 8'h33); acc(0, 0, 1, 0); chk("R5 D1 no flush", s_rd, 8'h11);
    push(8'h22); acc(1, 4, 1, 8'h60); acc(0, 4, 1, 0); chk("R5 60 flushes", s_rd, stat(0, 1));
    acc(1, 0, 1, 8'h05);

    // R7 device write
    push(8'h01); push(8'h02); push(8'h03);
    acc(1, 0, 1, 8'h99); chk("R7 ack irq", s_irq, 1);
    acc(0, 4, 1, 0); chk("R7 one byte queued", s_rd, stat(1, 0));
    acc(0, 0, 1, 0); chk("R7 ack byte", s_rd, 8'hFA); chk("R9 last pop no irq", s_irq, 0);
    acc(0, 4, 1, 0); chk("R10 avail cleared", s_rd, stat(0, 0));

    // R8 command sweep
    push(8'h77);
    for (int v = 0; v < 256; v++) begin
      if (!listed(8'(v))) begin
        acc(1, 4, 1, 8'(v));
        chk($sformatf("R8 miss count cmd 0x%0h", v), cnt_miss_wr, exp_mwr);
        if (s_rst) chk("R8 no reset pulse", s_rst, 0);
      end
    end
    acc(0, 4, 1, 0); chk("R8 status unchanged", s_rd, stat(1, 0));
    acc(0, 0, 1, 0); chk("R8 queue unchanged", s_rd, 8'h77);
    push(8'h44);
    acc(1, 4, 1, 8'hFE); chk("R8 reset pulse", s_rst, 1);
    @(negedge clk); chk("R8 pulse one cycle", sys_reset, 0);
    acc(0, 4, 1, 0); chk("R8 status after FE", s_rd, stat(1, 0));
    acc(0, 0, 1, 0); chk("R8 queue after FE", s_rd, 8'h44);
    acc(1, 4, 1, 8'h20); acc(0, 0, 1, 0); chk("R8 control unchanged", s_rd, 8'h05);

    // R2 widths and offsets
    for (int sz = 0; sz < 8; sz++) begin
      if (sz != 1) begin
        acc(1, 0, 3'(sz), 8'h55); acc(1, 4, 3'(sz), 8'hFE);
        chk("R2 wide write no reset", s_rst, 0);
        acc(0, 0, 3'(sz), 0); chk("R2 wide read zero", s_rd, 0);
      end
    end
    for (int a = 0; a < 8; a++) begin
      if (a != 0 && a != 4) begin
        acc(1, 3'(a), 1, 8'hFE); chk("R2 bad offset no reset", s_rst, 0);
        acc(0, 3'(a), 1, 0); chk("R2 bad offset read", s_rd, 0);
      end
    end
    acc(0, 4, 1, 0); chk("R2 ignored accesses left queue empty", s_rd, stat(0, 0));
    chk_counters("after R2");

    // R10 fill, overflow, drain
    model_q.delete();
    for (int i = 0; i < 16; i++) begin
      push(8'(i * 3 + 1)); model_q.push_back(8'(i * 3 + 1));
      chk("R10 accept", s_rej, 0); chk("R11 push irq", s_irq, 1);
    end
    push(8'hEE); chk("R10 full reject", s_rej, 1); chk("R12 no irq on reject", s_irq, 0);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = model_q.pop_front();
      acc(0, 0, 1, 0);
      chk($sformatf("R10 order %0d", i), s_rd, e);
      chk("R9 irq when bytes remain", s_irq, (model_q.size() > 0) ? 1 : 0);
    end
    acc(0, 4, 1, 0); chk("R10 avail after drain", s_rd, stat(0, 0));
    // wrap-around
    for (int i = 0; i < 5; i++) begin push(8'(8'h80 + i)); model_q.push_back(8'(8'h80 + i)); end
    for (int i = 0; i < 3; i++) begin
      logic [7:0] e;
      e = model_q.pop_front(); acc(0, 0, 1, 0); chk("R10 wrap pre", s_rd, e);
    end
    for (int i = 0; i < 14; i++) begin push(8'(8'hC0 + i)); model_q.push_back(8'(8'hC0 + i)); end
    push(8'h00); chk("R10 wrap full reject", s_rej, 1);
    while (model_q.size() > 0) begin
      logic [7:0] e;
      e = model_q.pop_front(); acc(0, 0, 1, 0); chk("R10 wrap order", s_rd, e);
    end
    acc(0, 0, 1, 0); chk("R9 empty after wrap", s_rd, 0);

    // R11 interrupt gating
    acc(1, 4, 1, 8'h60); acc(1, 0, 1, 8'h04);
    acc(1, 0, 1, 8'h10); chk("R11 ack irq suppressed", s_irq, 0);
    push(8'h21); chk("R11 push irq suppressed", s_irq, 0);
    acc(0, 0, 1, 0); chk("R11 read irq suppressed", s_irq, 0); chk("R7 ack first", s_rd, 8'hFA);
    acc(0, 0, 1, 0); chk("R11 queued byte", s_rd, 8'h21);
    acc(1, 4, 1, 8'h60); acc(1, 0, 1, 8'h05);

    // R12 push blocked during bus request
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4; req_size = 3'd1;
    push_valid = 1'b1; push_data = 8'hAB;
    #1 chk("R12 push_ready low", push_ready, 0);
    @(negedge clk);
    req_valid = 1'b0; push_valid = 1'b0;
    exp_rd = sat(exp_rd + 1);
    acc(0, 4, 1, 0); chk("R12 blocked push dropped", s_rd, stat(0, 0));
    chk_counters("before R13");

    // R13 saturation
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd4; req_size = 3'd1;
    repeat (65540) @(negedge clk);
    req_valid = 1'b0;
    exp_rd = sat(exp_rd + 65540);
    chk("R13 saturated read", cnt_read, 16'hFFFF);
    acc(0, 4, 1, 0); chk("R13 hold at top", cnt_read, 16'hFFFF);
    chk_counters("final");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule